// File: doc/BRIEF.md
# Debug Port Write Capture FIFO

This block sits behind a host I/O decoder that has already matched writes aimed at the debug code port. Each host write carries a size of one, two or four bytes, a starting byte lane and a 32-bit data bus. The block splits every accepted write into its bytes during the same clock. It tags each byte with the lane it came from and a sequence marker. It stores all of the resulting entries in a 16-entry FIFO within one cycle, so that a local controller can drain the power-on progress codes later.

The controller uses a small register port. Reading the data address returns one packed 16-bit word and removes the head entry. The word holds the byte, its lane, its sequence marker and a snapshot of the three status flags. A separate address returns the status flags alone and clears the sticky overrun flag on a write-one. A third address holds the fill threshold. The interrupt output stays high for as long as the FIFO holds at least the threshold number of entries.

A write is taken whole or not at all. When its bytes do not all fit, nothing is stored and the overrun flag is set.

Top module: `postcode_capture`

## Requirements
- R1: `wr_size` code 0 stores one byte from lane `wr_lane`. Code 1 stores two bytes from lanes {wr_lane[1],0} and {wr_lane[1],1}. Code 2 stores four bytes from lanes 0 to 3. Code 3 stores nothing and sets no flag. Lane k carries data bits [8k+7:8k]. The bytes of one write are pushed in ascending lane order.
- R2: A read at address 0 returns the byte in bits [7:0], the lane in bits [9:8], the sequence marker in bits [11:10] and status bits [2:0] in bits [14:12]. The status is sampled before that read's pop. Bit 15 is always zero.
- R3: The sequence marker is 00 for a one-byte write. For a multi-byte write it is 01 on the first byte, 10 on a middle byte and 11 on the last byte.
- R4: A read at address 0 removes exactly one entry. When the FIFO is empty, bits [11:0] read as zero and nothing changes.
- R5: A read at address 1 returns the status in bits [2:0] with all other bits zero. Bit 0 is not-empty, bit 1 is overrun and bit 2 is threshold reached. After reset the status is zero.
- R6: The free-space test uses the fill level at the start of the cycle and gives no credit for a pop in the same cycle. A write whose bytes exceed the free space is discarded completely and sets overrun. Overrun stays set until a write to address 1 with bit 1 high clears it. A new overrun in the same cycle as that clear wins.
- R7: Address 2 holds the threshold. It resets to 8. A write of 1 to 16 is stored. A write of any other value is ignored. A read returns the threshold in the low bits.
- R8: `irq` and status bit 2 are high exactly while the fill level is at or above the threshold. Both follow the fill level from the cycle after the push or pop.
- R9: The FIFO holds 16 entries. Four 4-byte writes fill it with no overrun.
- R10: A push and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write strobe, one cycle per write |
| wr_size | input | 2 | Size code: 0 one byte, 1 two bytes, 2 four bytes, 3 none |
| wr_lane | input | 2 | Starting byte lane of the write |
| wr_data | input | 32 | Host write data, lane k in bits [8k+7:8k] |
| reg_rd_en | input | 1 | Register read strobe; pops when the address is 0 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 data, 1 status, 2 threshold, 3 unused |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Combinational read data for the current address |
| irq | output | 1 | High while fill level is at or above the threshold |

## Verification
The hardest state to reach from the ports is a full FIFO that is popped and written in the same cycle. The fill level must sit exactly at the boundary, the read must land on the data address and the host write must arrive together with it. Only then does the rule of no credit for the same-cycle pop become visible as an overrun. The stimulus reaches this state on purpose by filling with four 4-byte writes and then issuing a combined read and write. The random phase biases toward large writes and sparse reads, so that the fill level keeps returning to the full boundary with mixed sizes, lanes and threshold values.

// File: rtl/pcap_pkg.sv
`timescale 1ns/1ps
package pcap_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int NB_W   = $clog2(LANES + 1);
  localparam int MAX_SZ = $clog2(LANES);

  typedef enum logic [1:0] {
    SEQ_SINGLE = 2'b00,
    SEQ_FIRST  = 2'b01,
    SEQ_MID    = 2'b10,
    SEQ_LAST   = 2'b11
  } seq_e;

  typedef enum logic [1:0] {
    RA_DATA = 2'd0,
    RA_STAT = 2'd1,
    RA_THR  = 2'd2,
    RA_NONE = 2'd3
  } raddr_e;

  typedef struct packed {
    seq_e              seq;
    logic [LANE_W-1:0] lane;
    logic [BYTE_W-1:0] data;
  } entry_t;

  localparam int ST_NE  = 0;
  localparam int ST_OVR = 1;
  localparam int ST_THR = 2;
endpackage

// File: rtl/pcap_split.sv
`timescale 1ns/1ps
module pcap_split
  import pcap_pkg::*;
(
  input  logic [1:0]              size,
  input  logic [LANE_W-1:0]       lane,
  input  logic [DATA_W-1:0]       data,
  output entry_t [LANES-1:0]      ents,
  output logic [NB_W-1:0]         n_bytes
);
  logic [LANE_W-1:0] mask;
  logic [LANE_W-1:0] base;

  always_comb begin
    n_bytes = '0;
    mask    = '0;
    if (int'(size) <= MAX_SZ) begin
      n_bytes = NB_W'(1 << size);
      mask    = LANE_W'((1 << size) - 1);
    end
    base = lane & ~mask;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] idx;
    always_comb begin
      idx                = base + LANE_W'(g);
      ents[g].lane       = idx;
      ents[g].data       = data[BYTE_W*int'(idx) +: BYTE_W];
      if (n_bytes == NB_W'(1))
        ents[g].seq = SEQ_SINGLE;
      else if (g == 0)
        ents[g].seq = SEQ_FIRST;
      else if (g == int'(n_bytes) - 1)
        ents[g].seq = SEQ_LAST;
      else
        ents[g].seq = SEQ_MID;
    end
  end
endmodule

// File: rtl/pcap_fifo.sv
`timescale 1ns/1ps
module pcap_fifo
  import pcap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NB_W-1:0]     push_n,
  input  entry_t [LANES-1:0]  push_ent,
  input  logic                pop,
  output entry_t              head,
  output logic [CNT_W-1:0]    count
);
  logic [PTR_W-1:0] wptr_q, wptr_nxt;
  logic [PTR_W-1:0] rptr_q, rptr_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  entry_t           mem [DEPTH];

  always_comb begin
    wptr_nxt = wptr_q + PTR_W'(push_n);
    rptr_nxt = rptr_q + PTR_W'(pop);
    cnt_nxt  = cnt_q + CNT_W'(push_n) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_nxt;
      rptr_q <= rptr_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_wr
    always_ff @(posedge clk) begin
      if (NB_W'(g) < push_n)
        mem[wptr_q + PTR_W'(g)] <= push_ent[g];
    end
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/pcap_regs.sv
`timescale 1ns/1ps
module pcap_regs
  import pcap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  entry_t           head,
  input  logic             ovr_evt,
  input  logic             reg_rd_en,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic             pop,
  output logic             irq,
  output logic [15:0]      reg_rdata,
  output logic [CNT_W-1:0] thr_q,
  output logic             ovr_q
);
  logic [CNT_W-1:0] thr_nxt;
  logic             ovr_nxt;
  logic             thr_ld;
  logic             ovr_clr;
  logic [2:0]       status;
  entry_t           shown;

  always_comb begin
    thr_ld  = reg_wr_en && (reg_addr == RA_THR) &&
              (int'(reg_wdata) >= 1) && (int'(reg_wdata) <= DEPTH);
    thr_nxt = thr_ld ? CNT_W'(reg_wdata) : thr_q;
    ovr_clr = reg_wr_en && (reg_addr == RA_STAT) && reg_wdata[ST_OVR];
    ovr_nxt = ovr_evt || (ovr_q && !ovr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= CNT_W'(DEPTH / 2);
      ovr_q <= 1'b0;
    end else begin
      thr_q <= thr_nxt;
      ovr_q <= ovr_nxt;
    end
  end

  always_comb begin
    status[ST_NE]  = (count != '0);
    status[ST_OVR] = ovr_q;
    status[ST_THR] = (count >= thr_q);
    irq            = status[ST_THR];
    pop            = reg_rd_en && (reg_addr == RA_DATA) && status[ST_NE];
    shown          = status[ST_NE] ? head : '0;
    case (reg_addr)
      RA_DATA: reg_rdata = {1'b0, status, shown};
      RA_STAT: reg_rdata = {13'd0, status};
      RA_THR:  reg_rdata = 16'(thr_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/postcode_capture.sv
`timescale 1ns/1ps
module postcode_capture
  import pcap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [1:0]  wr_size,
  input  logic [1:0]  wr_lane,
  input  logic [31:0] wr_data,
  input  logic        reg_rd_en,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  entry_t [LANES-1:0] ents;
  logic [NB_W-1:0]    n_bytes;
  logic [NB_W-1:0]    push_n;
  logic [CNT_W-1:0]   fifo_count;
  entry_t             head;
  logic               pop;
  logic               fits;
  logic               ovr_evt;
  logic [CNT_W-1:0]   thr_q;
  logic               sts_ovr;

  pcap_split u_split (
    .size    (wr_size),
    .lane    (wr_lane),
    .data    (wr_data),
    .ents    (ents),
    .n_bytes (n_bytes)
  );

  always_comb begin
    fits    = int'(n_bytes) <= (DEPTH - int'(fifo_count));
    push_n  = (wr_valid && fits) ? n_bytes : '0;
    ovr_evt = wr_valid && (n_bytes != '0) && !fits;
  end

  pcap_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (push_n),
    .push_ent (ents),
    .pop      (pop),
    .head     (head),
    .count    (fifo_count)
  );

  pcap_regs #(.DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (fifo_count),
    .head      (head),
    .ovr_evt   (ovr_evt),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pop       (pop),
    .irq       (irq),
    .reg_rdata (reg_rdata),
    .thr_q     (thr_q),
    .ovr_q     (sts_ovr)
  );
endmodule

// File: rtl/pcap_chk.sv
`timescale 1ns/1ps
module pcap_chk
  import pcap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [NB_W-1:0]  n_bytes,
  input logic             reg_rd_en,
  input logic             reg_wr_en,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic [15:0]      reg_rdata,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] thr,
  input logic             ovr,
  input logic             irq
);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && n_bytes != '0 && int'(n_bytes) > DEPTH - int'(count)) |=> ovr);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(reg_wr_en && reg_addr == 2'd1 && reg_wdata[1])) |=> ovr);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !wr_valid) |=> count == '0);

  assert_top_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> !reg_rdata[15]);

  assert_thr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(thr) >= 1 && int'(thr) <= DEPTH);

  assert_irq_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count != '0);

  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && int'(n_bytes) <= DEPTH - int'(count) && !(reg_rd_en && reg_addr == 2'd0))
    |=> int'(count) == int'($past(count)) + int'($past(n_bytes)));
endmodule

bind postcode_capture pcap_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .n_bytes   (n_bytes),
  .reg_rd_en (reg_rd_en),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .count     (fifo_count),
  .thr       (thr_q),
  .ovr       (sts_ovr),
  .irq       (irq)
);

// File: tb/test_postcode_capture.sv
`timescale 1ns/1ps
module test_postcode_capture;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [1:0]  wr_size;
  logic [1:0]  wr_lane;
  logic [31:0] wr_data;
  logic        reg_rd_en;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [11:0] mq[$];
  bit  m_ovr;
  int  m_thr;

  always #4 clk = ~clk;

  postcode_capture i_postcode_capture (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_size(wr_size),
    .wr_lane(wr_lane), .wr_data(wr_data), .reg_rd_en(reg_rd_en),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd3) ? 0 : (1 << sz);
  endfunction

  // Model push per R1 and R3
  function automatic void model_push(input logic [1:0] sz, input logic [1:0] ln, input logic [31:0] d);
    int n = nbytes(sz);
    int base = (sz == 2'd0) ? int'(ln) : (sz == 2'd1) ? int'(ln) & 2 : 0;
    for (int i = 0; i < n; i++) begin
      logic [1:0] sq;
      int l = base + i;
      if (n == 1) sq = 2'b00;
      else if (i == 0) sq = 2'b01;
      else if (i == n - 1) sq = 2'b11;
      else sq = 2'b10;
      mq.push_back({sq, 2'(l), d[8*l +: 8]});
    end
  endfunction

  function automatic logic [2:0] model_status();
    return {mq.size() >= m_thr, m_ovr, mq.size() != 0};
  endfunction

  task automatic step(input bit wv, input logic [1:0] sz, input logic [1:0] ln,
                      input logic [31:0] d, input bit rd, input bit wr,
                      input logic [1:0] a, input logic [7:0] wd);
    logic [2:0] st;
    int cnt0;
    bit ovr_set;
    @(negedge clk);
    wr_valid = wv; wr_size = sz; wr_lane = ln; wr_data = d;
    reg_rd_en = rd; reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
    #1;
    st = model_status();
    check("R8 irq level", 32'(irq), 32'(st[2]));
    if (rd) begin
      case (a)
        2'd0: check("R2/R4 data word", 32'(reg_rdata),
                    32'({1'b0, st, (mq.size() != 0) ? mq[0] : 12'h000}));
        2'd1: check("R5 status word", 32'(reg_rdata), 32'({13'd0, st}));
        2'd2: check("R7 threshold readback", 32'(reg_rdata), 32'(m_thr));
        default: check("R5 unused address", 32'(reg_rdata), 32'd0);
      endcase
    end
    @(posedge clk);
    cnt0 = mq.size();
    ovr_set = 1'b0;
    if (rd && a == 2'd0 && cnt0 > 0) void'(mq.pop_front());
    if (wv && nbytes(sz) > 0) begin
      if (nbytes(sz) <= DEPTH - cnt0) model_push(sz, ln, d);
      else ovr_set = 1'b1;
    end
    if (wr && a == 2'd1 && wd[1]) m_ovr = 1'b0;
    if (ovr_set) m_ovr = 1'b1;
    if (wr && a == 2'd2 && wd >= 1 && wd <= DEPTH) m_thr = int'(wd);
  endtask

  task automatic hwr(input logic [1:0] sz, input logic [1:0] ln, input logic [31:0] d);
    step(1'b1, sz, ln, d, 1'b0, 1'b0, 2'd3, 8'h00);
  endtask
  task automatic rrd(input logic [1:0] a);
    step(1'b0, 2'd0, 2'd0, 32'h0, 1'b1, 1'b0, a, 8'h00);
  endtask
  task automatic rwr(input logic [1:0] a, input logic [7:0] wd);
    step(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 1'b1, a, wd);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    wr_valid = 0; wr_size = 0; wr_lane = 0; wr_data = 0;
    reg_rd_en = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
    m_ovr = 0; m_thr = 8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 R7: reset state
    rrd(2'd1);
    rrd(2'd2);
    rrd(2'd0);  // R4 empty read
    check("R4 empty read leaves status", 32'(model_status()), 32'd0);
    rrd(2'd3);

    // R1 R3: mixed sizes and lanes, then drain
    hwr(2'd2, 2'd1, 32'hDDCCBBAA);
    hwr(2'd1, 2'd3, 32'h11223344);
    hwr(2'd0, 2'd1, 32'h00005500);
    hwr(2'd3, 2'd0, 32'hFFFFFFFF);  // R1 size code 3 ignored
    rrd(2'd1);
    check("R1 entries after mixed writes", 32'(mq.size()), 32'd7);
    repeat (8) rrd(2'd0);

    // R9 R6: fill to 16, then overflow
    for (int k = 0; k < 4; k++) hwr(2'd2, 2'd0, 32'h01020304 * (k + 1));
    rrd(2'd1);  // R9 full, no overrun
    hwr(2'd0, 2'd0, 32'h000000EE);  // R6 overflow
    rrd(2'd1);
    rwr(2'd1, 8'h02);               // R6 clear
    rrd(2'd1);
    // R6: full, pop and write in one cycle -> no credit, overrun
    step(1'b1, 2'd0, 2'd2, 32'h00AB0000, 1'b1, 1'b0, 2'd0, 8'h00);
    rrd(2'd1);
    // R6: clear and new overrun together -> set wins
    hwr(2'd2, 2'd0, 32'h0);
    step(1'b1, 2'd2, 2'd0, 32'h12345678, 1'b0, 1'b1, 2'd1, 8'h02);
    rrd(2'd1);
    rwr(2'd1, 8'h02);
    repeat (17) rrd(2'd0);

    // R7 threshold range, R8 irq around threshold
    rwr(2'd2, 8'd0);  rrd(2'd2);
    rwr(2'd2, 8'd17); rrd(2'd2);
    rwr(2'd2, 8'd3);  rrd(2'd2);
    hwr(2'd1, 2'd0, 32'h0000BEEF);
    rrd(2'd1);
    hwr(2'd0, 2'd3, 32'h7F000000);
    rrd(2'd1);
    // R10: push and pop in one cycle
    step(1'b1, 2'd1, 2'd2, 32'hCAFE0000, 1'b1, 1'b0, 2'd0, 8'h00);
    check("R10 fill after push+pop", 32'(mq.size()), 32'd4);
    rrd(2'd1);
    repeat (5) rrd(2'd0);

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 45)
        hwr(2'($urandom_range(0, 3) == 0 ? 2'($urandom_range(0, 3)) : 2'd2),
            2'($urandom_range(0, 3)), $urandom());
      else if (r < 60)
        step(1'b1, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), $urandom(),
             1'b1, 1'b0, 2'd0, 8'h00);
      else if (r < 85) rrd(2'($urandom_range(0, 3)));
      else if (r < 93) rwr(2'd1, 8'($urandom_range(0, 255)));
      else rwr(2'd2, 8'($urandom_range(0, 20)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule